// File: doc/BRIEF.md
# Howling-Prevention Attenuator Steering

This block serves one voice channel and handles linear PCM samples at the 8 kHz frame rate. Each frame it receives one receive-direction sample and one send-direction sample. For each direction it keeps a short-term level estimate and judges whether that direction is active. From the two activity states it picks exactly one of the two outgoing paths and attenuates that path by 6 dB. The other path passes unchanged. This lowers the loop gain around a hands-free speaker and microphone so that howling cannot build up.

The level estimate is a first-order leaky average of the sample magnitude, and it is updated once per frame. A direction counts as active while its average is above a programmable threshold. It also stays active for a programmable number of frames after the average falls back, so the selection does not chatter. An active-low enable turns the attenuation on. While the enable is high, both paths pass through unchanged.

Top module: `howl_att_steer`

## Requirements
- R1: On each frame strobe, each direction's level average updates as avg + floor((|x| - avg) / 2^LEAK), where x is the sample of that frame. Both averages start at 0.
- R2: On a frame where a direction's updated average is above the threshold, the hangover counter of that direction loads `hang_i`. On any other frame, a nonzero counter decreases by one. A direction is active while its average is above the threshold or its counter is nonzero.
- R3: When the receive direction is active and the send direction is not, the send output is attenuated and `rx_att_o` is 0.
- R4: When the receive direction is silent, or when both directions are active, the receive output is attenuated and `rx_att_o` is 1.
- R5: With attenuation enabled, exactly one of the two outputs is attenuated in every frame.
- R6: Attenuation is a 1-bit arithmetic right shift, which rounds toward minus infinity. For example, -3 becomes -2 and 7 becomes 3.
- R7: While `att_dis_n` is 1, both outputs equal their inputs. `rx_att_o` still reports the steering decision.
- R8: After reset both outputs are 0, `rx_att_o` is 1, and both directions count as silent.
- R9: Outputs and `rx_att_o` change only on the clock edge that samples `frame_i` high. The samples of a frame are steered by the activity state that was in place before that frame's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | One-cycle frame strobe; the samples are valid in that cycle |
| att_dis_n | input | 1 | 0 enables attenuation, 1 passes both paths through |
| rin_i | input | W | Signed receive-direction input sample |
| sin_i | input | W | Signed send-direction input sample |
| thr_i | input | W | Unsigned activity threshold |
| hang_i | input | HW | Hangover length in frames |
| rout_o | output | W | Receive-direction output sample |
| sout_o | output | W | Send-direction output sample |
| rx_att_o | output | 1 | 1: receive path attenuated; 0: send path attenuated |

## Verification
The assertions check on every cycle that outputs hold between frame strobes, that pass-through is exact while attenuation is disabled, that the steering rule picks the correct path and shifts only that path, and that each level average stays within its magnitude range. The bench's scenarios are needed to show how long the hangover lasts, the exact rounding of the leaky average as it rises and decays, and the transitions between receive-only, both-active and silent conditions. A behavioural model runs next to the design and is compared with it on every clock.

// File: rtl/howl_att_steer.sv
module howl_att_steer #(
  parameter int W    = 16,
  parameter int LEAK = 3,
  parameter int HW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_i,
  input  logic                att_dis_n,
  input  logic signed [W-1:0] rin_i,
  input  logic signed [W-1:0] sin_i,
  input  logic        [W-1:0] thr_i,
  input  logic       [HW-1:0] hang_i,
  output logic signed [W-1:0] rout_o,
  output logic signed [W-1:0] sout_o,
  output logic                rx_att_o
);
  localparam int AW = W + 1;

  logic [AW-1:0] avg_r_q, avg_s_q, avg_r_d, avg_s_d;
  logic [HW-1:0] hng_r_q, hng_s_q;
  logic [AW-1:0] thr_x;
  logic          act_r, act_s, tx_sel;

  function automatic logic [AW-1:0] mag(input logic signed [W-1:0] x);
    logic signed [AW-1:0] xs;
    xs = AW'(x);
    return (xs < 0) ? AW'(-xs) : AW'(xs);
  endfunction

  function automatic logic [AW-1:0] leak(input logic [AW-1:0] avg, input logic [AW-1:0] m);
    logic signed [AW+1:0] d, s;
    d = $signed({2'b00, m}) - $signed({2'b00, avg});
    s = $signed({2'b00, avg}) + (d >>> LEAK);
    return s[AW-1:0];
  endfunction

  function automatic logic [HW-1:0] hang_nxt(input logic hi, input logic [HW-1:0] cur,
                                              input logic [HW-1:0] ld);
    if (hi) return ld;
    else if (cur != '0) return cur - 1'b1;
    else return cur;
  endfunction

  assign thr_x   = {1'b0, thr_i};
  assign avg_r_d = leak(avg_r_q, mag(rin_i));
  assign avg_s_d = leak(avg_s_q, mag(sin_i));
  assign act_r   = (avg_r_q > thr_x) || (hng_r_q != '0);
  assign act_s   = (avg_s_q > thr_x) || (hng_s_q != '0);
  assign tx_sel  = act_r && !act_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avg_r_q  <= '0;
      avg_s_q  <= '0;
      hng_r_q  <= '0;
      hng_s_q  <= '0;
      rout_o   <= '0;
      sout_o   <= '0;
      rx_att_o <= 1'b1;
    end else if (frame_i) begin
      rout_o   <= (!att_dis_n && !tx_sel) ? (rin_i >>> 1) : rin_i;
      sout_o   <= (!att_dis_n &&  tx_sel) ? (sin_i >>> 1) : sin_i;
      rx_att_o <= !tx_sel;
      avg_r_q  <= avg_r_d;
      avg_s_q  <= avg_s_d;
      hng_r_q  <= hang_nxt(avg_r_d > thr_x, hng_r_q, hang_i);
      hng_s_q  <= hang_nxt(avg_s_d > thr_x, hng_s_q, hang_i);
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> ($stable(rout_o) && $stable(sout_o) && $stable(rx_att_o)));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && att_dis_n) |=> (rout_o == $past(rin_i) && sout_o == $past(sin_i)));

  assert_tx_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && !att_dis_n && act_r && !act_s) |=>
      (!rx_att_o && sout_o == ($past(sin_i) >>> 1) && rout_o == $past(rin_i)));

  assert_rx_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && !att_dis_n && (!act_r || act_s)) |=>
      (rx_att_o && rout_o == ($past(rin_i) >>> 1) && sout_o == $past(sin_i)));

  always_comb begin
    assert_avg_bound_R1: assert (!rst_n || (avg_r_q <= AW'(1 << (W-1)) && avg_s_q <= AW'(1 << (W-1))));
  end
endmodule

// File: tb/howl_att_steer_tb_top.sv
module howl_att_steer_tb_top;
  localparam int W = 16, LEAK = 3, HW = 8;

  logic clk = 0, rst_n = 0, frame_i = 0, att_dis_n = 0;
  logic signed [W-1:0] rin_i = 0, sin_i = 0;
  logic [W-1:0] thr_i = 16'd1000;
  logic [HW-1:0] hang_i = 8'd3;
  logic signed [W-1:0] rout_o, sout_o;
  logic rx_att_o;

  howl_att_steer #(.W(W), .LEAK(LEAK), .HW(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .att_dis_n(att_dis_n),
    .rin_i(rin_i), .sin_i(sin_i), .thr_i(thr_i), .hang_i(hang_i),
    .rout_o(rout_o), .sout_o(sout_o), .rx_att_o(rx_att_o));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_req = "R8";
  int m_ar, m_as, m_hr, m_hs, e_rout, e_sout, e_att;

  function automatic int absv(int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic model_tick();
    bit ar, as, tx;
    if (!rst_n) begin
      m_ar = 0; m_as = 0; m_hr = 0; m_hs = 0; e_rout = 0; e_sout = 0; e_att = 1;
    end else if (frame_i) begin
      ar = (m_ar > int'(thr_i)) || (m_hr != 0);
      as = (m_as > int'(thr_i)) || (m_hs != 0);
      tx = ar && !as;
      e_rout = (!att_dis_n && !tx) ? (int'(rin_i) >>> 1) : int'(rin_i);
      e_sout = (!att_dis_n && tx) ? (int'(sin_i) >>> 1) : int'(sin_i);
      e_att  = tx ? 0 : 1;
      m_ar = m_ar + ((absv(int'(rin_i)) - m_ar) >>> LEAK);
      m_as = m_as + ((absv(int'(sin_i)) - m_as) >>> LEAK);
      if (m_ar > int'(thr_i)) m_hr = int'(hang_i); else if (m_hr != 0) m_hr--;
      if (m_as > int'(thr_i)) m_hs = int'(hang_i); else if (m_hs != 0) m_hs--;
    end
  endtask

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    model_tick();
    chk(cur_req, int'(rout_o), e_rout, "rout_o");
    chk(cur_req, int'(sout_o), e_sout, "sout_o");
    chk(cur_req, int'(rx_att_o), e_att, "rx_att_o");
    @(negedge clk);
  endtask

  task automatic frame(int r, int s);
    rin_i = r[W-1:0]; sin_i = s[W-1:0]; frame_i = 1;
    cyc();
    frame_i = 0;
    for (int i = 0; i < 3; i++) cyc();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1;
    chk("R8", int'(rout_o), 0, "reset rout");
    chk("R8", int'(sout_o), 0, "reset sout");
    chk("R8", int'(rx_att_o), 1, "reset flag");

    cur_req = "R4";
    for (int i = 0; i < 3; i++) frame(100, 50);
    chk("R4", int'(rx_att_o), 1, "silent flag");
    chk("R6", int'(rout_o), 50, "silent rout shifted");

    cur_req = "R3";
    for (int i = 0; i < 6; i++) frame(8000, 0);
    chk("R3", int'(rx_att_o), 0, "rx only flag");
    frame(8000, -3);
    chk("R6", int'(sout_o), -2, "shift of -3");
    frame(8000, 7);
    chk("R6", int'(sout_o), 3, "shift of 7");

    cur_req = "R2";
    for (int i = 0; i < 30; i++) frame(0, 0);
    chk("R2", int'(rx_att_o), 1, "after hangover");

    cur_req = "R4";
    for (int i = 0; i < 6; i++) frame(8000, 9000);
    chk("R4", int'(rx_att_o), 1, "both active flag");
    for (int i = 0; i < 30; i++) frame(0, 6000);
    chk("R4", int'(rx_att_o), 1, "send only flag");
    chk("R5", int'(sout_o), 6000, "send only unattenuated");

    cur_req = "R9";
    frame_i = 0; rin_i = 16'sd1234; sin_i = -16'sd999;
    for (int i = 0; i < 5; i++) cyc();
    chk("R9", int'(sout_o), 6000, "held without strobe");

    cur_req = "R7";
    att_dis_n = 1;
    frame(-32768, 32767);
    chk("R7", int'(rout_o), -32768, "pass rout");
    chk("R7", int'(sout_o), 32767, "pass sout");
    att_dis_n = 0;

    cur_req = "R1";
    hang_i = 0;
    for (int i = 0; i < 30; i++) frame(0, 0);
    for (int i = 0; i < 10; i++) frame(-32768, 0);
    chk("R1", int'(rx_att_o), 0, "rx loud with max magnitude");
    for (int i = 0; i < 40; i++) frame(i * 37 - 500, 0);

    cur_req = "R8";
    rst_n = 0; cyc(); rst_n = 1;
    chk("R8", int'(rx_att_o), 1, "mid-run reset flag");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule